// File: doc/BRIEF.md
# Indexed CPU Register Port for a Raster Display Controller

This block is the 8-bit processor-facing side of a raster display controller. The processor reaches eighteen data registers, numbered R0 to R17, through a single index register. One select line chooses between the index and the data register that the index points at. A read/write line gives the direction. An active-low chip select qualifies the cycle. A bus enable strobe times each access: a write takes effect when the strobe falls, and read data is presented while the strobe is high.

Read data leaves on its own output bus. A drive flag beside it tells an external bidirectional wrapper when to turn its pads around. Every stored field is also presented in parallel to the timing, cursor and light pen logic. Light pen capture values come back in through a load strobe and are readable from the port.

The block samples the bus strobe with the controller clock. It has a synchronous active-low reset and an asynchronous active-low power-up reset.

Top module: `crtc_regif`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the index, all eighteen data registers and every parallel output clear to zero after that edge.
- R2: A write cycle with `bus_rs` low loads the index from the low 5 bits of `bus_wdata`. The upper 3 bits are dropped, so a write of 0xEE selects index 14.
- R3: A write cycle with `bus_rs` high stores `bus_wdata` into the data register named by the index. The matching parallel output takes the new value after the clock edge at which the strobe is first seen low, having been seen high at the edge before. In `timing_regs`, register Rk (k = 0..11) occupies bits [8k+7:8k].
- R4: No register changes unless all of the following hold at that falling-strobe edge: `bus_cs_n` is low and `bus_rnw` is low. The strobe merely being high also changes nothing.
- R5: R12 and R14 keep only bits [5:0]. `start_addr` is {R12[5:0], R13} and `cursor_addr` is {R14[5:0], R15}. Reading R12 or R14 returns bits [7:6] as zero.
- R6: With `bus_rs` high, reads of indices 12 to 17 return the stored value. Reads of indices 0 to 11 and 18 to 31 return zero, and so does any read with `bus_rs` low. `bus_rdata` is zero whenever `bus_drive` is low.
- R7: `bus_drive` is high exactly while `bus_cs_n` is low, `bus_rnw` is high and `bus_en` is high. It follows those inputs in the same cycle.
- R8: Data writes to indices 16 to 31 change no register and no output.
- R9: In every clock cycle with `lpen_load` high, `lpen_addr[13:8]` is stored in R16 and `lpen_addr[7:0]` in R17.
- R10: Driving `por_n` low clears every register at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; all state changes on its rising edge |
| por_n | input | 1 | Asynchronous power-up reset, active low |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rs | input | 1 | 0 selects the index, 1 selects the indexed data register |
| bus_rnw | input | 1 | 1 read, 0 write |
| bus_en | input | 1 | Bus strobe; writes commit on its fall, reads drive while high |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor, zero when not driving |
| bus_drive | output | 1 | High while the external wrapper should drive the shared bus |
| lpen_load | input | 1 | Loads the light pen capture registers this cycle |
| lpen_addr | input | 14 | Captured refresh address from the light pen logic |
| timing_regs | output | 96 | R0 to R11, eight bits each, R0 in the lowest byte |
| start_addr | output | 14 | Display start address {R12[5:0], R13} |
| cursor_addr | output | 14 | Cursor address {R14[5:0], R15} |

## Verification
`bus_rdata` and `bus_drive` are combinational from the bus inputs and stored state. The bench therefore checks them at the falling clock edge of the same cycle in which it sets up the read. Register and output updates land one edge after the strobe is seen low, which is two rising edges after the write data and strobe are raised. Light pen loads land one edge after `lpen_load`. Each stimulus task returns only after its commit edge, and every compare is queued and sampled at the next falling edge, so no check looks at a value that is still due. The power-up reset is checked at the falling edge that follows its assertion, with no rising edge in between.

// File: rtl/crtc_regif_pkg.sv
package crtc_regif_pkg;
    localparam int NUM_TIMING   = 12;
    localparam int REG_START_HI = 12;
    localparam int REG_START_LO = 13;
    localparam int REG_CUR_HI   = 14;
    localparam int REG_CUR_LO   = 15;
    localparam int REG_LPEN_HI  = 16;
    localparam int REG_LPEN_LO  = 17;
endpackage

// File: rtl/crtc_bus_decode.sv
module crtc_bus_decode #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             bus_cs_n,
    input  logic             bus_rs,
    input  logic             bus_rnw,
    input  logic             bus_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] idx,
    output logic             data_wr,
    output logic             bus_drive
);
    typedef struct packed {
        logic             en_q;
        logic [IDX_W-1:0] idx;
    } dec_t;

    dec_t state_d, state_q;
    logic strobe_fall_d, access_wr_d;

    always_comb begin
        state_d       = state_q;
        strobe_fall_d = state_q.en_q & ~bus_en;
        access_wr_d   = strobe_fall_d & ~bus_cs_n & ~bus_rnw;
        data_wr       = access_wr_d & bus_rs;
        bus_drive     = ~bus_cs_n & bus_rnw & bus_en;
        state_d.en_q  = bus_en;
        if (access_wr_d && !bus_rs) begin
            state_d.idx = wr_idx;
        end
        if (!rst_n) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign idx = state_q.idx;

    // R1: synchronous reset returns the index to zero
    p_reset_idx_r1: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (idx == '0));

    // R3: a commit is a single-cycle event per strobe fall
    p_single_commit_r3: assert property (@(posedge clk) disable iff (!por_n)
        data_wr |=> !data_wr);
endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
    import crtc_regif_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 5,
    parameter int AHI_W   = 6,
    parameter int NUM_TIM = NUM_TIMING
) (
    input  logic                      clk,
    input  logic                      por_n,
    input  logic                      rst_n,
    input  logic                      data_wr,
    input  logic [IDX_W-1:0]          idx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      lpen_load,
    input  logic [AHI_W+DATA_W-1:0]   lpen_addr,
    output logic [NUM_TIM*DATA_W-1:0] timing_regs,
    output logic [AHI_W-1:0]          start_hi,
    output logic [DATA_W-1:0]         start_lo,
    output logic [AHI_W-1:0]          cur_hi,
    output logic [DATA_W-1:0]         cur_lo,
    output logic [AHI_W-1:0]          lpen_hi,
    output logic [DATA_W-1:0]         lpen_lo
);
    localparam int ADDR_W = AHI_W + DATA_W;

    typedef struct packed {
        logic [NUM_TIM-1:0][DATA_W-1:0] tim;
        logic [AHI_W-1:0]               start_hi;
        logic [DATA_W-1:0]              start_lo;
        logic [AHI_W-1:0]               cur_hi;
        logic [DATA_W-1:0]              cur_lo;
        logic [AHI_W-1:0]               lpen_hi;
        logic [DATA_W-1:0]              lpen_lo;
    } bank_t;

    bank_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (data_wr) begin
            for (int k = 0; k < NUM_TIM; k++) begin
                if (idx == IDX_W'(k)) begin
                    state_d.tim[k] = wdata;
                end
            end
            if (idx == IDX_W'(REG_START_HI)) state_d.start_hi = wdata[AHI_W-1:0];
            if (idx == IDX_W'(REG_START_LO)) state_d.start_lo = wdata;
            if (idx == IDX_W'(REG_CUR_HI))   state_d.cur_hi   = wdata[AHI_W-1:0];
            if (idx == IDX_W'(REG_CUR_LO))   state_d.cur_lo   = wdata;
        end
        if (lpen_load) begin
            state_d.lpen_hi = lpen_addr[ADDR_W-1:DATA_W];
            state_d.lpen_lo = lpen_addr[DATA_W-1:0];
        end
        if (!rst_n) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim_out
        assign timing_regs[g*DATA_W +: DATA_W] = state_q.tim[g];
    end

    assign start_hi = state_q.start_hi;
    assign start_lo = state_q.start_lo;
    assign cur_hi   = state_q.cur_hi;
    assign cur_lo   = state_q.cur_lo;
    assign lpen_hi  = state_q.lpen_hi;
    assign lpen_lo  = state_q.lpen_lo;

    // R4: without a committed data write the stored fields do not move
    p_hold_without_commit_r4: assert property (@(posedge clk) disable iff (!por_n)
        (!data_wr && rst_n) |=> ($stable(timing_regs) && $stable(start_hi) &&
                                 $stable(start_lo) && $stable(cur_hi) && $stable(cur_lo)));

    // R8: light pen registers change only through the capture load
    p_lpen_read_only_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!lpen_load && rst_n) |=> ($stable(lpen_hi) && $stable(lpen_lo)));
endmodule

// File: rtl/crtc_read_mux.sv
module crtc_read_mux
    import crtc_regif_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5,
    parameter int AHI_W  = 6
) (
    input  logic              bus_drive,
    input  logic              bus_rs,
    input  logic [IDX_W-1:0]  idx,
    input  logic [AHI_W-1:0]  start_hi,
    input  logic [DATA_W-1:0] start_lo,
    input  logic [AHI_W-1:0]  cur_hi,
    input  logic [DATA_W-1:0] cur_lo,
    input  logic [AHI_W-1:0]  lpen_hi,
    input  logic [DATA_W-1:0] lpen_lo,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] sel_d;

    always_comb begin
        sel_d = '0;
        if (idx == IDX_W'(REG_START_HI))      sel_d = DATA_W'(start_hi);
        else if (idx == IDX_W'(REG_START_LO)) sel_d = start_lo;
        else if (idx == IDX_W'(REG_CUR_HI))   sel_d = DATA_W'(cur_hi);
        else if (idx == IDX_W'(REG_CUR_LO))   sel_d = cur_lo;
        else if (idx == IDX_W'(REG_LPEN_HI))  sel_d = DATA_W'(lpen_hi);
        else if (idx == IDX_W'(REG_LPEN_LO))  sel_d = lpen_lo;
        rdata = (bus_drive && bus_rs) ? sel_d : '0;
    end
endmodule

// File: rtl/crtc_regif.sv
module crtc_regif
    import crtc_regif_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 5,
    parameter int AHI_W   = 6,
    parameter int NUM_TIM = NUM_TIMING,
    localparam int ADDR_W = AHI_W + DATA_W
) (
    input  logic                      clk,
    input  logic                      por_n,
    input  logic                      rst_n,
    input  logic                      bus_cs_n,
    input  logic                      bus_rs,
    input  logic                      bus_rnw,
    input  logic                      bus_en,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_drive,
    input  logic                      lpen_load,
    input  logic [ADDR_W-1:0]         lpen_addr,
    output logic [NUM_TIM*DATA_W-1:0] timing_regs,
    output logic [ADDR_W-1:0]         start_addr,
    output logic [ADDR_W-1:0]         cursor_addr
);
    logic [IDX_W-1:0]  idx;
    logic              data_wr;
    logic [AHI_W-1:0]  start_hi, cur_hi, lpen_hi;
    logic [DATA_W-1:0] start_lo, cur_lo, lpen_lo;

    crtc_bus_decode #(.IDX_W(IDX_W)) u_decode (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .bus_cs_n  (bus_cs_n),
        .bus_rs    (bus_rs),
        .bus_rnw   (bus_rnw),
        .bus_en    (bus_en),
        .wr_idx    (bus_wdata[IDX_W-1:0]),
        .idx       (idx),
        .data_wr   (data_wr),
        .bus_drive (bus_drive)
    );

    crtc_reg_bank #(
        .DATA_W (DATA_W), .IDX_W (IDX_W), .AHI_W (AHI_W), .NUM_TIM (NUM_TIM)
    ) u_bank (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .data_wr     (data_wr),
        .idx         (idx),
        .wdata       (bus_wdata),
        .lpen_load   (lpen_load),
        .lpen_addr   (lpen_addr),
        .timing_regs (timing_regs),
        .start_hi    (start_hi),
        .start_lo    (start_lo),
        .cur_hi      (cur_hi),
        .cur_lo      (cur_lo),
        .lpen_hi     (lpen_hi),
        .lpen_lo     (lpen_lo)
    );

    crtc_read_mux #(.DATA_W(DATA_W), .IDX_W(IDX_W), .AHI_W(AHI_W)) u_rmux (
        .bus_drive (bus_drive),
        .bus_rs    (bus_rs),
        .idx       (idx),
        .start_hi  (start_hi),
        .start_lo  (start_lo),
        .cur_hi    (cur_hi),
        .cur_lo    (cur_lo),
        .lpen_hi   (lpen_hi),
        .lpen_lo   (lpen_lo),
        .rdata     (bus_rdata)
    );

    assign start_addr  = {start_hi, start_lo};
    assign cursor_addr = {cur_hi, cur_lo};

    // R6: the read bus stays quiet whenever the pads are not being driven
    p_rdata_quiet_r6: assert property (@(posedge clk) disable iff (!por_n)
        !bus_drive |-> (bus_rdata == '0));

    // R5: six-bit high bytes read back with the top bits clear
    p_hi_byte_width_r5: assert property (@(posedge clk) disable iff (!por_n)
        (bus_drive && bus_rs && (idx == IDX_W'(REG_START_HI) || idx == IDX_W'(REG_CUR_HI)))
        |-> (bus_rdata[DATA_W-1:AHI_W] == '0));

    // R1: synchronous reset empties the parallel address outputs
    p_reset_outputs_r1: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (start_addr == '0 && cursor_addr == '0 && timing_regs == '0));
endmodule

// File: tb/crtc_regif_bench.sv
`timescale 1ns/1ps
module crtc_regif_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1;
    logic        bus_rs = 1'b0;
    logic        bus_rnw = 1'b1;
    logic        bus_en = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        bus_drive;
    logic        lpen_load = 1'b0;
    logic [13:0] lpen_addr = 14'h0;
    logic [95:0] timing_regs;
    logic [13:0] start_addr;
    logic [13:0] cursor_addr;

    always #4 clk = ~clk;

    crtc_regif u_crtc_regif (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .bus_cs_n(bus_cs_n), .bus_rs(bus_rs), .bus_rnw(bus_rnw), .bus_en(bus_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_drive(bus_drive),
        .lpen_load(lpen_load), .lpen_addr(lpen_addr),
        .timing_regs(timing_regs), .start_addr(start_addr), .cursor_addr(cursor_addr)
    );

    // selectors: 0 rdata, 1 drive, 2 start_addr, 3 cursor_addr, 10+k timing byte k
    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    logic  mon_req  = 1'b0;

    function automatic logic [15:0] observe(int sel);
        if (sel == 0) return {8'h00, bus_rdata};
        if (sel == 1) return {15'h0, bus_drive};
        if (sel == 2) return {2'b00, start_addr};
        if (sel == 3) return {2'b00, cursor_addr};
        return {8'h00, timing_regs[(sel-10)*8 +: 8]};
    endfunction

    always @(negedge clk) begin
        if (mon_req && q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = q.pop_front();
            act = observe(it.sel);
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    // all tasks start and end just after a rising edge
    task automatic expect_now(int sel, logic [15:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        q.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic bus_write(logic rs, logic [7:0] d);
        bus_cs_n = 1'b0; bus_rnw = 1'b0; bus_rs = rs; bus_wdata = d; bus_en = 1'b1;
        @(posedge clk); #1;
        bus_en = 1'b0;
        @(posedge clk); #1;
        bus_cs_n = 1'b1; bus_rnw = 1'b1;
    endtask

    task automatic wr_reg(logic [7:0] index, logic [7:0] d);
        bus_write(1'b0, index);
        bus_write(1'b1, d);
    endtask

    task automatic rd_reg(logic [7:0] index, logic [7:0] exp, string tag);
        bus_write(1'b0, index);
        bus_cs_n = 1'b0; bus_rnw = 1'b1; bus_rs = 1'b1; bus_en = 1'b1;
        expect_now(1, 16'h1, tag);
        expect_now(0, {8'h00, exp}, tag);
        bus_en = 1'b0;
        @(posedge clk); #1;
        bus_cs_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #10 por_n = 1'b1;
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        expect_now(2, 16'h0, "R1 start_addr after reset");
        expect_now(3, 16'h0, "R1 cursor_addr after reset");
        expect_now(10, 16'h0, "R1 R0 after reset");
        expect_now(1, 16'h0, "R7 drive idle");

        // R3 data write lands on the parallel outputs
        wr_reg(8'd0, 8'h63);
        expect_now(10, 16'h63, "R3 R0 output");
        wr_reg(8'd11, 8'hA5);
        expect_now(21, 16'hA5, "R3 R11 output");
        expect_now(10, 16'h63, "R3 R0 kept");
        rd_reg(8'd0, 8'h00, "R6 R0 write-only reads zero");

        // R5 start and cursor addresses
        wr_reg(8'd12, 8'hFF);
        wr_reg(8'd13, 8'h34);
        expect_now(2, 16'h3F34, "R5 start_addr");
        rd_reg(8'd12, 8'h3F, "R5 R12 readback");
        rd_reg(8'd13, 8'h34, "R6 R13 readback");
        wr_reg(8'd14, 8'h12);
        wr_reg(8'd15, 8'hAB);
        expect_now(3, 16'h12AB, "R5 cursor_addr");
        rd_reg(8'd15, 8'hAB, "R6 R15 readback");

        // R2 index keeps the low five bits: 0xEE -> 14
        bus_write(1'b0, 8'hEE);
        bus_write(1'b1, 8'h05);
        expect_now(3, 16'h05AB, "R2 index truncation");

        // R8 writes to read-only and unused indices
        wr_reg(8'd16, 8'h55);
        rd_reg(8'd16, 8'h00, "R8 R16 unchanged");
        wr_reg(8'd20, 8'h77);
        rd_reg(8'd20, 8'h00, "R8 R6 index 20 reads zero");
        expect_now(2, 16'h3F34, "R8 start kept");
        expect_now(3, 16'h05AB, "R8 cursor kept");

        // R4 unselected or read-direction strobes write nothing
        bus_write(1'b0, 8'd13);
        bus_rs = 1'b1; bus_wdata = 8'h99; bus_rnw = 1'b0; bus_cs_n = 1'b1; bus_en = 1'b1;
        @(posedge clk); #1; bus_en = 1'b0;
        @(posedge clk); #1;
        expect_now(2, 16'h3F34, "R4 cs high no write");
        bus_cs_n = 1'b0; bus_rnw = 1'b1; bus_en = 1'b1;
        @(posedge clk); #1; bus_en = 1'b0;
        @(posedge clk); #1; bus_cs_n = 1'b1;
        expect_now(2, 16'h3F34, "R4 read strobe no write");
        bus_cs_n = 1'b0; bus_rnw = 1'b0; bus_en = 1'b1;
        @(posedge clk); #1;
        expect_now(2, 16'h3F34, "R4 strobe high only");
        bus_cs_n = 1'b1;
        @(posedge clk); #1; bus_en = 1'b0;
        @(posedge clk); #1; bus_rnw = 1'b1;
        expect_now(2, 16'h3F34, "R4 cs dropped before fall");

        // R6 / R7 index-select reads and drive gating
        bus_cs_n = 1'b0; bus_rnw = 1'b1; bus_rs = 1'b0; bus_en = 1'b1;
        expect_now(1, 16'h1, "R7 drive on read");
        expect_now(0, 16'h0, "R6 rs low reads zero");
        bus_en = 1'b0;
        expect_now(1, 16'h0, "R7 drive off with strobe low");
        bus_cs_n = 1'b1;

        // R9 light pen capture
        lpen_addr = 14'h2A5C; lpen_load = 1'b1;
        @(posedge clk); #1;
        lpen_load = 1'b0; lpen_addr = 14'h1111;
        rd_reg(8'd16, 8'h2A, "R9 R16 capture");
        rd_reg(8'd17, 8'h5C, "R9 R17 capture");

        // R1 synchronous reset
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        expect_now(2, 16'h0, "R1 start cleared");
        expect_now(21, 16'h0, "R1 R11 cleared");
        rd_reg(8'd17, 8'h00, "R1 R17 cleared");

        // R10 asynchronous power-up reset
        wr_reg(8'd13, 8'h42);
        expect_now(2, 16'h0042, "R10 setup");
        por_n = 1'b0;
        expect_now(2, 16'h0, "R10 async clear");
        por_n = 1'b1;
        @(posedge clk); #1;

        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard residue actual=%0d expected=0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule